// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is the target side of a two-wire serial memory. It watches the clock and data lines of the bus through synchronizers running on a faster system clock. It recognises START and STOP conditions and answers a select byte that carries its three strap bits. It keeps a word address counter that persists between accesses and serves reads and writes to an on-chip byte array. The block never drives the data line high. It pulls it low through an output enable, and the bus pull-up supplies every one.

A write-direction access carries two address bytes and loads the counter. If the access then ends, the transfer was a dummy write and only the address has changed. A repeated START with a read-direction select then fetches from that location, which gives a random read. A read-direction select with no address phase reads from wherever the counter stands. Data bytes that follow the address bytes in a write access are stored. The counter advances after every byte moved, and it wraps to zero.

The bus interface is dictated by the two-wire protocol, so it has no valid/ready handshake. The master applies back-pressure only by holding the clock line, and the target follows whatever clock rate it sees, as long as the system clock is at least eight times faster. The strap pins are plain static inputs.

Top module: `twim_target`

## Requirements
- R1: The select byte, sent most significant bit first, is 1010 followed by the three strap bits and then a direction bit (0 = write, 1 = read). It is acknowledged only when the strap bits equal `chip_sel`. On a mismatch the target drives nothing until the next START.
- R2: After a write select, the upper and lower address bytes are each acknowledged. Bit 7 of the upper byte is discarded, and the remaining 15 bits are loaded into the address counter.
- R3: After a dummy write and a repeated START with a read select, the target shifts out the byte stored at the loaded address, most significant bit first.
- R4: A data byte that follows the two address bytes is acknowledged and stored at the counter address.
- R5: A read select with no address phase returns the byte at the counter as it stands from the previous access.
- R6: The counter advances by one after every byte read or written and wraps from 0x7FFF to 0. When the master acknowledges a read byte, the next byte follows from the advanced address.
- R7: When the master does not acknowledge a read byte and then issues STOP, the read ends and the target releases SDA.
- R8: The target changes its SDA drive only while SCL is low. Acknowledges occupy the ninth clock of an accepted byte.
- R9: A START (SDA falling while SCL is high) at any point restarts select-byte reception and abandons any partly received byte without storing it. A STOP (SDA rising while SCL is high) returns the target to idle.
- R10: The array holds 2**MEM_AW bytes and is indexed by the low MEM_AW bits of the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel | input | 3 | Strap bits compared with the select byte |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | When high, the pad pulls SDA low |

## Verification
Condition detection and the bit engine can both act in the same system cycle. A START may arrive while the engine is partway through a data byte or holding a pending edge action. In that case the condition must win, and the byte being received must be dropped. The bench provokes this by breaking off a write data byte after four bits with a repeated START. It judges the outcome by two results: the new select byte is acknowledged, and a later random read of that address still returns the byte written before.

// File: rtl/twim_pkg.sv
package twim_pkg;
  localparam logic [3:0] TWIM_FAMILY = 4'b1010;
  localparam int TWIM_SEL_W = 3;
  localparam int TWIM_CNT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_WDATA,
    ST_RDATA
  } twim_state_e;
endpackage

// File: rtl/twim_sync.sv
module twim_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d,
  output logic [LINES-1:0] q,
  output logic [LINES-1:0] q_prev
);
  // Each line passes through STAGES flops, plus one more for edge detection.
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-1:0], d[i]};
    end
    assign q[i]      = chain[STAGES-1];
    assign q_prev[i] = chain[STAGES];
  end
endmodule

// File: rtl/twim_cond.sv
module twim_cond (
  input  logic scl_s,
  input  logic sda_s,
  input  logic scl_p,
  input  logic sda_p,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_held;
  assign scl_held  = scl_s & scl_p;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_held & sda_p & ~sda_s;
  assign stop_det  = scl_held & ~sda_p & sda_s;
endmodule

// File: rtl/twim_mem.sv
module twim_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/twim_engine.sv
module twim_engine
  import twim_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sda_s,
  input  logic                  scl_rise,
  input  logic                  scl_fall,
  input  logic                  start_det,
  input  logic                  stop_det,
  input  logic [TWIM_SEL_W-1:0] chip_sel,
  input  logic [7:0]            rd_data,
  output logic [ADDR_W-1:0]     addr,
  output logic                  addr_load,
  output logic                  wr_en,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [7:0]            wr_data,
  output logic                  sda_oe,
  output logic                  active
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [TWIM_CNT_W-1:0] BIT_LAST = TWIM_CNT_W'(8);
  localparam logic [TWIM_CNT_W-1:0] BIT_ACK  = TWIM_CNT_W'(9);

  twim_state_e           st;
  logic [TWIM_CNT_W-1:0] cnt;     // SCL rises seen in the current 9-clock frame
  logic [7:0]            sr;
  logic                  rw;
  logic                  mack;
  logic [HI_W-1:0]       hi_q;
  logic                  sel_hit;

  assign sel_hit = (sr[7:1] == {TWIM_FAMILY, chip_sel});
  assign active  = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sr        <= '0;
      rw        <= 1'b0;
      mack      <= 1'b0;
      hi_q      <= '0;
      addr      <= '0;
      addr_load <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      sda_oe    <= 1'b0;
    end else begin
      addr_load <= 1'b0;
      wr_en     <= 1'b0;
      if (start_det) begin
        // a START outranks every edge action of this cycle
        st     <= ST_DEVSEL;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (cnt != BIT_ACK) cnt <= cnt + 1'b1;
          if (st != ST_RDATA && cnt < BIT_LAST) sr <= {sr[6:0], sda_s};
          if (st == ST_RDATA && cnt == BIT_LAST) mack <= ~sda_s;
        end else if (scl_fall) begin
          if (cnt == BIT_LAST) begin
            // end of the eighth bit: open the acknowledge slot
            unique case (st)
              ST_DEVSEL: begin
                if (sel_hit) begin
                  sda_oe <= 1'b1;
                  rw     <= sr[0];
                end else begin
                  st <= ST_IDLE;
                end
              end
              ST_ADDR_HI: begin
                hi_q   <= sr[HI_W-1:0];
                sda_oe <= 1'b1;
              end
              ST_ADDR_LO: begin
                addr      <= {hi_q, sr};
                addr_load <= 1'b1;
                sda_oe    <= 1'b1;
              end
              ST_WDATA: begin
                wr_en   <= 1'b1;
                wr_addr <= addr;
                wr_data <= sr;
                addr    <= addr + 1'b1;
                sda_oe  <= 1'b1;
              end
              ST_RDATA: begin
                addr   <= addr + 1'b1;
                sda_oe <= 1'b0;
              end
              default: st <= ST_IDLE;
            endcase
          end else if (cnt == BIT_ACK) begin
            // end of the ninth clock: close the frame
            cnt    <= '0;
            sda_oe <= 1'b0;
            unique case (st)
              ST_DEVSEL: begin
                if (rw) begin
                  st     <= ST_RDATA;
                  sr     <= rd_data;
                  sda_oe <= ~rd_data[7];
                end else begin
                  st <= ST_ADDR_HI;
                end
              end
              ST_ADDR_HI: st <= ST_ADDR_LO;
              ST_ADDR_LO: st <= ST_WDATA;
              ST_WDATA:   st <= ST_WDATA;
              ST_RDATA: begin
                if (mack) begin
                  sr     <= rd_data;
                  sda_oe <= ~rd_data[7];
                end else begin
                  st <= ST_IDLE;
                end
              end
              default: st <= ST_IDLE;
            endcase
          end else if (st == ST_RDATA) begin
            sda_oe <= ~sr[6];
            sr     <= {sr[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/twim_target.sv
module twim_target
  import twim_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int MEM_AW      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TWIM_SEL_W-1:0] chip_sel,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe
);
  logic scl_s, sda_s, scl_p, sda_p;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] cur_addr;
  logic              addr_load;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic [7:0]        rd_data;
  logic              eng_active;

  twim_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      ({scl_i, sda_i}),
    .q      ({scl_s, sda_s}),
    .q_prev ({scl_p, sda_p})
  );

  twim_cond u_cond (
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_p     (scl_p),
    .sda_p     (sda_p),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twim_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .chip_sel  (chip_sel),
    .rd_data   (rd_data),
    .addr      (cur_addr),
    .addr_load (addr_load),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe),
    .active    (eng_active)
  );

  twim_mem #(.AW(MEM_AW), .DW(8)) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr[MEM_AW-1:0]),
    .wdata (wr_data),
    .raddr (cur_addr[MEM_AW-1:0]),
    .rdata (rd_data)
  );
endmodule

// File: rtl/twim_target_chk.sv
module twim_target_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic              sda_oe,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              addr_load,
  input logic              active
);
  logic [ADDR_W-1:0] prev_addr;
  logic [ADDR_W-1:0] step_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_addr <= '0;
    else        prev_addr <= cur_addr;
  end
  assign step_addr = prev_addr + 1'b1;

  // R8: drive only moves while the synchronized clock was low
  p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

  // R9: a START leaves the target released and waiting for a select byte
  p_start_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!sda_oe && active));

  // R7: a STOP leaves the target released and idle
  p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && !active));

  // R6: the counter only steps by one (wrapping) unless an address is loaded
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_addr != prev_addr) && !addr_load) |-> (cur_addr == step_addr));

  // R1: the line is never pulled while the target is unselected
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> active);
endmodule

bind twim_target twim_target_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe),
  .cur_addr  (cur_addr),
  .addr_load (addr_load),
  .active    (eng_active)
);

// File: tb/twim_target_bench.sv
module twim_target_bench;
  localparam int Q = 10;            // system clocks per quarter SCL period
  localparam int WATCHDOG = 150000;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] SEL_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] SEL_R = {4'b1010, STRAP, 1'b1};
  localparam int NVEC = 6;
  // {address[15:0], data[7:0]}; low address bytes distinct so no aliasing
  localparam logic [23:0] VEC [NVEC] = '{
    24'h0000_3C, 24'h1234_A7, 24'h00FF_01, 24'h7F80_FE, 24'h8055_69, 24'h0A0A_80
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_line;
  int checks = 0;
  int errors = 0;
  int oe_viol = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz
  assign sda_line = m_sda & ~sda_oe;

  twim_target u_twim_target (
    .clk      (clk),
    .rst_n    (rst_n),
    .chip_sel (STRAP),
    .scl_i    (m_scl),
    .sda_i    (sda_line),
    .sda_oe   (sda_oe)
  );

  // R8 monitor: the drive must not move while the bench holds SCL high
  always @(sda_oe) if (rst_n && m_scl) oe_viol++;

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic bo, output logic bi);
    m_sda = bo; wq();
    m_scl = 1'b1; wq();
    bi = sda_line; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nack);
    logic dummy;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], dummy);
    bit_cycle(1'b1, nack);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic dummy;
    for (int i = 7; i >= 0; i--) bit_cycle(1'b1, b[i]);
    bit_cycle(~give_ack, dummy);
  endtask

  task automatic addr_phase(input logic [15:0] a);
    logic nk;
    bus_start();
    send_byte(SEL_W, nk);      chk("R1 select ack", {15'd0, nk}, 16'd0);
    send_byte(a[15:8], nk);    chk("R2 upper addr ack", {15'd0, nk}, 16'd0);
    send_byte(a[7:0], nk);     chk("R2 lower addr ack", {15'd0, nk}, 16'd0);
  endtask

  task automatic write1(input logic [15:0] a, input logic [7:0] d);
    logic nk;
    addr_phase(a);
    send_byte(d, nk);          chk("R4 data ack", {15'd0, nk}, 16'd0);
    bus_stop();
  endtask

  task automatic read_open();
    logic nk;
    bus_start();
    send_byte(SEL_R, nk);      chk("R3 read select ack", {15'd0, nk}, 16'd0);
  endtask

  task automatic read_close(input logic [7:0] last_exp, input logic [7:0] got, input string tag);
    chk(tag, {8'd0, got}, {8'd0, last_exp});
    bus_stop();
    chk("R7 released after stop", {15'd0, sda_oe}, 16'd0);
  endtask

  initial begin
    logic nk;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    chk("R7 reset release", {15'd0, sda_oe}, 16'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 idle after reset", {15'd0, sda_oe}, 16'd0);

    // table: byte write each vector, then random read it back
    for (int i = 0; i < NVEC; i++) begin
      write1(VEC[i][23:8], VEC[i][7:0]);
    end
    for (int i = 0; i < NVEC; i++) begin
      addr_phase(VEC[i][23:8]);          // dummy write
      read_open();
      recv_byte(1'b0, b);
      read_close(VEC[i][7:0], b, "R3 R10 random read data");
    end

    // R1: wrong strap bits get no acknowledge, and nothing is driven after
    bus_start();
    send_byte({4'b1010, 3'b001, 1'b0}, nk); chk("R1 mismatch nack", {15'd0, nk}, 16'd1);
    send_byte(8'h00, nk);                   chk("R1 ignored byte nack", {15'd0, nk}, 16'd1);
    bus_stop();
    bus_start();
    send_byte({4'b1010, 3'b001, 1'b1}, nk); chk("R1 mismatch read nack", {15'd0, nk}, 16'd1);
    recv_byte(1'b0, b);                     chk("R1 no read drive", {8'd0, b}, 16'h00FF);
    bus_stop();

    // R5: current-address read after a random read of 0x0040
    write1(16'h0040, 8'h11);
    write1(16'h0041, 8'h22);
    addr_phase(16'h0040);
    read_open();
    recv_byte(1'b0, b);
    read_close(8'h11, b, "R3 read 0x0040");
    read_open();
    recv_byte(1'b0, b);
    read_close(8'h22, b, "R5 current-address read");

    // R6: sequential read with master acknowledge
    addr_phase(16'h0040);
    read_open();
    recv_byte(1'b1, b);        chk("R6 seq byte 0", {8'd0, b}, 16'h0011);
    recv_byte(1'b0, b);
    read_close(8'h22, b, "R6 seq byte 1");

    // R6: two data bytes in one write access cross the top address
    addr_phase(16'h7FFF);
    send_byte(8'hA5, nk);      chk("R4 first data ack", {15'd0, nk}, 16'd0);
    send_byte(8'h5A, nk);      chk("R6 wrapped data ack", {15'd0, nk}, 16'd0);
    bus_stop();
    addr_phase(16'h7FFF);
    read_open();
    recv_byte(1'b1, b);        chk("R6 wrap byte top", {8'd0, b}, 16'h00A5);
    recv_byte(1'b0, b);
    read_close(8'h5A, b, "R6 wrap byte zero");

    // R9: START four bits into a data byte abandons it
    write1(16'h0050, 8'h33);
    addr_phase(16'h0050);
    bit_cycle(1'b1, nk); bit_cycle(1'b0, nk); bit_cycle(1'b1, nk); bit_cycle(1'b1, nk);
    bus_start();
    send_byte(SEL_W, nk);      chk("R9 select after mid-byte start", {15'd0, nk}, 16'd0);
    send_byte(8'h00, nk);      chk("R9 upper addr ack", {15'd0, nk}, 16'd0);
    send_byte(8'h50, nk);      chk("R9 lower addr ack", {15'd0, nk}, 16'd0);
    read_open();
    recv_byte(1'b0, b);
    read_close(8'h33, b, "R9 aborted byte not stored");

    // R9: STOP straight after the select byte returns to idle
    bus_start();
    send_byte(SEL_W, nk);      chk("R9 select ack", {15'd0, nk}, 16'd0);
    bus_stop();
    repeat (Q) @(negedge clk);
    chk("R9 idle after stop", {15'd0, sda_oe}, 16'd0);

    chk("R8 drive moved while SCL high", oe_viol[15:0], 16'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule